// File: doc/BRIEF.md
# In-band control cell handler for a switch port

This block sits in the cell path of one switch port. Each clock cycle it may receive one whole cell (header plus a 64-bit payload word). Ordinary data cells are passed on after one register stage. On the way, their VCI is replaced by the entry that the virtual-circuit routing table holds for them, and they are counted both on the link counter and on a per-circuit counter.

A cell that carries the reserved VPI/VCI pair is a control cell, but only while the port's control-reception input is high. A control cell never reaches the data output and is never counted. When its target-port byte names this port, the command in its payload is executed and a response cell is produced. When it names another port, it is passed unchanged to a forwarding output so that it can travel toward that port.

Commands read and write routing table entries, write and read a hardware option register, and read the link counter or a per-circuit counter. Every response carries a time stamp: the value of a free-running cycle counter in the cycle the data was sampled. Software can therefore measure load over short intervals by taking the difference of two reads.

Top module: `ccell_handler`

## Requirements
- R1: A data cell presented in cycle t appears on the data output in cycle t+1. Its VPI and payload are unchanged, and its VCI is replaced by the routing entry indexed by the low log2(NVC) bits of its VCI.
- R2: A cell is a control cell only when its VPI equals RSV_VPI, its VCI equals RSV_VCI and ctl_en is high. With ctl_en low, such a cell is handled, translated and counted as data.
- R3: A control cell whose target byte (payload bits 55:48) differs from my_port appears unchanged on fwd_pay in cycle t+1. It is not executed, and it is absent from the data output.
- R4: A local control cell gives a response in cycle t+1 that echoes its opcode (bits 63:56) and address (bits 47:32). Opcode 0x01 returns the routing entry at the address. Opcode 0x02 writes data bits VCI_W-1:0 into that entry and echoes the data word. A written entry is used by any cell that follows.
- R5: Opcode 0x03 writes the 32-bit data word (bits 31:0) to opt_out, visible in cycle t+1. Opcode 0x06 returns opt_out. No other cell changes opt_out.
- R6: The link counter counts every data cell. Control cells are not counted. Opcode 0x04 returns the link counter, including all data cells presented before the command.
- R7: Each circuit index has its own data-cell counter. Opcode 0x05 returns the counter selected by the address.
- R8: rsp_stamp equals the number of clock cycles between the release of reset and the cycle in which the command was presented.
- R9: An undefined opcode, or an address of NVC or more used with opcode 0x01, 0x02 or 0x05, returns rsp_err=1 and rsp_data=0 and changes no state.
- R10: Counters wrap modulo 2^CNT_W and are not cleared by reading.
- R11: After reset all valid outputs are low, opt_out is 0 and all counters and table entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Port accepts control cells |
| my_port | input | 8 | This port's number |
| in_valid | input | 1 | Cell present this cycle |
| in_vpi | input | VPI_W | Cell VPI |
| in_vci | input | VCI_W | Cell VCI |
| in_pay | input | 64 | Payload: opcode[63:56], target[55:48], address[47:32], data[31:0] |
| dout_valid | output | 1 | Data cell out |
| dout_vpi | output | VPI_W | Data cell VPI |
| dout_vci | output | VCI_W | Translated VCI |
| dout_pay | output | 64 | Data cell payload |
| fwd_valid | output | 1 | Control cell for another port |
| fwd_pay | output | 64 | Forwarded control payload |
| rsp_valid | output | 1 | Response cell out |
| rsp_err | output | 1 | Command rejected |
| rsp_op | output | 8 | Echoed opcode |
| rsp_addr | output | 16 | Echoed address |
| rsp_data | output | 32 | Read or echoed data |
| rsp_stamp | output | STAMP_W | Cycle count when the data was sampled |
| opt_out | output | 32 | Hardware option register |

## Verification
Every result of this block is due exactly one cycle after its cell is presented. This holds for the translated data cell, the forwarded control cell and the response with its stamp. A table or option write takes effect for any cell presented in the following cycle, and a counter read reports all data cells presented before it. The bench applies one cell per cycle, 2 ns after a rising edge. It predicts the outputs from its own model state for that cycle and compares them 2 ns after the next rising edge, so each comparison falls one register stage after its stimulus.

// File: rtl/ccell_pkg.sv
package ccell_pkg;
   localparam int PAY_W  = 64;
   localparam int OP_W   = 8;
   localparam int TGT_W  = 8;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;

   typedef enum logic [OP_W-1:0] {
      OP_TAB_RD  = 8'h01,
      OP_TAB_WR  = 8'h02,
      OP_OPT_WR  = 8'h03,
      OP_LINK_RD = 8'h04,
      OP_VC_RD   = 8'h05,
      OP_OPT_RD  = 8'h06
   } ccell_op_e;

   typedef struct packed {
      logic [OP_W-1:0]   op;
      logic [TGT_W-1:0]  tgt;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } ccell_cmd_t;
endpackage

// File: rtl/ccell_classify.sv
module ccell_classify #(
   parameter int VPI_W = 8,
   parameter int VCI_W = 16,
   parameter logic [VPI_W-1:0] RSV_VPI = '0,
   parameter logic [VCI_W-1:0] RSV_VCI = '0
) (
   input  logic             valid,
   input  logic             ctl_en,
   input  logic [VPI_W-1:0] vpi,
   input  logic [VCI_W-1:0] vci,
   input  logic [7:0]       tgt,
   input  logic [7:0]       my_port,
   output logic             is_data,
   output logic             is_local,
   output logic             is_fwd
);
   logic is_ctl;
   always_comb begin
      is_ctl   = valid && ctl_en && (vpi == RSV_VPI) && (vci == RSV_VCI);
      is_data  = valid && !is_ctl;
      is_local = is_ctl && (tgt == my_port);
      is_fwd   = is_ctl && (tgt != my_port);
   end
endmodule

// File: rtl/ccell_vctab.sv
module ccell_vctab #(
   parameter int NVC   = 16,
   parameter int ENT_W = 16,
   localparam int IDXW = $clog2(NVC)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDXW-1:0]  widx,
   input  logic [ENT_W-1:0] wdat,
   input  logic [IDXW-1:0]  ridx_a,
   input  logic [IDXW-1:0]  ridx_b,
   output logic [ENT_W-1:0] rdat_a,
   output logic [ENT_W-1:0] rdat_b
);
   logic [ENT_W-1:0] ent [NVC];

   for (genvar g = 0; g < NVC; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (rst)
            ent[g] <= '0;
         else if (we && (widx == IDXW'(g)))
            ent[g] <= wdat;
      end
   end

   assign rdat_a = ent[ridx_a];
   assign rdat_b = ent[ridx_b];
endmodule

// File: rtl/ccell_counters.sv
module ccell_counters #(
   parameter int NVC   = 16,
   parameter int CNT_W = 32,
   localparam int IDXW = $clog2(NVC)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   input  logic [IDXW-1:0]  inc_idx,
   input  logic [IDXW-1:0]  rd_idx,
   output logic [CNT_W-1:0] link_cnt,
   output logic [CNT_W-1:0] vc_cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt [NVC];

   always_ff @(posedge clk) begin
      if (rst)
         link_cnt <= '0;
      else if (inc)
         link_cnt <= link_cnt + ONE;
   end

   for (genvar g = 0; g < NVC; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (rst)
            cnt[g] <= '0;
         else if (inc && (inc_idx == IDXW'(g)))
            cnt[g] <= cnt[g] + ONE;
      end
   end

   assign vc_cnt = cnt[rd_idx];
endmodule

// File: rtl/ccell_handler.sv
module ccell_handler
   import ccell_pkg::*;
#(
   parameter int VPI_W   = 8,
   parameter int VCI_W   = 16,
   parameter int NVC     = 16,
   parameter int CNT_W   = 32,
   parameter int STAMP_W = 32,
   parameter logic [VPI_W-1:0] RSV_VPI = '0,
   parameter logic [VCI_W-1:0] RSV_VCI = VCI_W'(3)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ctl_en,
   input  logic [7:0]         my_port,
   input  logic               in_valid,
   input  logic [VPI_W-1:0]   in_vpi,
   input  logic [VCI_W-1:0]   in_vci,
   input  logic [63:0]        in_pay,
   output logic               dout_valid,
   output logic [VPI_W-1:0]   dout_vpi,
   output logic [VCI_W-1:0]   dout_vci,
   output logic [63:0]        dout_pay,
   output logic               fwd_valid,
   output logic [63:0]        fwd_pay,
   output logic               rsp_valid,
   output logic               rsp_err,
   output logic [7:0]         rsp_op,
   output logic [15:0]        rsp_addr,
   output logic [31:0]        rsp_data,
   output logic [STAMP_W-1:0] rsp_stamp,
   output logic [31:0]        opt_out
);
   localparam int IDXW = $clog2(NVC);
   localparam logic [ADDR_W-1:0] NVC_A = ADDR_W'(NVC);
   localparam logic [STAMP_W-1:0] S_ONE = STAMP_W'(1);

   if (NVC < 2 || (1 << IDXW) != NVC || NVC > 65536)
      $error("NVC must be a power of two between 2 and 65536");
   if (CNT_W < 1 || CNT_W > DATA_W)
      $error("CNT_W must be 1..32");
   if (VCI_W > DATA_W || VCI_W < IDXW)
      $error("VCI_W out of range");
   if (STAMP_W < 1)
      $error("STAMP_W must be positive");

   ccell_cmd_t cmd;
   assign cmd = ccell_cmd_t'(in_pay);

   logic is_data, is_local, is_fwd;
   ccell_classify #(.VPI_W(VPI_W), .VCI_W(VCI_W), .RSV_VPI(RSV_VPI), .RSV_VCI(RSV_VCI)) u_cls (
      .valid(in_valid), .ctl_en(ctl_en), .vpi(in_vpi), .vci(in_vci),
      .tgt(cmd.tgt), .my_port(my_port),
      .is_data(is_data), .is_local(is_local), .is_fwd(is_fwd));

   logic            addr_ok;
   logic [IDXW-1:0] aidx, didx;
   assign addr_ok = cmd.addr < NVC_A;
   assign aidx    = cmd.addr[IDXW-1:0];
   assign didx    = in_vci[IDXW-1:0];

   logic             tab_we;
   logic [VCI_W-1:0] tab_data, tab_cmd;
   assign tab_we = is_local && (cmd.op == OP_TAB_WR) && addr_ok;
   ccell_vctab #(.NVC(NVC), .ENT_W(VCI_W)) u_tab (
      .clk(clk), .rst(rst), .we(tab_we), .widx(aidx), .wdat(cmd.data[VCI_W-1:0]),
      .ridx_a(didx), .ridx_b(aidx), .rdat_a(tab_data), .rdat_b(tab_cmd));

   logic [CNT_W-1:0] link_cnt, vc_cnt;
   ccell_counters #(.NVC(NVC), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(is_data), .inc_idx(didx), .rd_idx(aidx),
      .link_cnt(link_cnt), .vc_cnt(vc_cnt));

   logic [STAMP_W-1:0] stamp;
   always_ff @(posedge clk) begin
      if (rst) stamp <= '0;
      else     stamp <= stamp + S_ONE;
   end

   logic        r_err;
   logic [31:0] r_data;
   always_comb begin
      r_err  = 1'b0;
      r_data = '0;
      case (cmd.op)
         OP_TAB_RD:  if (addr_ok) r_data = DATA_W'(tab_cmd); else r_err = 1'b1;
         OP_TAB_WR:  if (addr_ok) r_data = cmd.data;         else r_err = 1'b1;
         OP_OPT_WR:  r_data = cmd.data;
         OP_OPT_RD:  r_data = opt_out;
         OP_LINK_RD: r_data = DATA_W'(link_cnt);
         OP_VC_RD:   if (addr_ok) r_data = DATA_W'(vc_cnt);  else r_err = 1'b1;
         default:    r_err = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_valid <= 1'b0;
         fwd_valid  <= 1'b0;
         rsp_valid  <= 1'b0;
         opt_out    <= '0;
      end else begin
         dout_valid <= is_data;
         fwd_valid  <= is_fwd;
         rsp_valid  <= is_local;
         if (is_local && cmd.op == OP_OPT_WR)
            opt_out <= cmd.data;
      end
   end

   always_ff @(posedge clk) begin
      if (is_data) begin
         dout_vpi <= in_vpi;
         dout_vci <= tab_data;
         dout_pay <= in_pay;
      end
      if (is_fwd)
         fwd_pay <= in_pay;
      if (is_local) begin
         rsp_err   <= r_err;
         rsp_op    <= cmd.op;
         rsp_addr  <= cmd.addr;
         rsp_data  <= r_data;
         rsp_stamp <= stamp;
      end
   end
endmodule

// File: rtl/ccell_handler_chk.sv
module ccell_handler_chk #(
   parameter int VPI_W   = 8,
   parameter int VCI_W   = 16,
   parameter int STAMP_W = 32,
   parameter logic [VPI_W-1:0] RSV_VPI = '0,
   parameter logic [VCI_W-1:0] RSV_VCI = '0
) (
   input logic               clk,
   input logic               rst,
   input logic               ctl_en,
   input logic [7:0]         my_port,
   input logic               in_valid,
   input logic [VPI_W-1:0]   in_vpi,
   input logic [VCI_W-1:0]   in_vci,
   input logic [63:0]        in_pay,
   input logic               dout_valid,
   input logic [VPI_W-1:0]   dout_vpi,
   input logic [63:0]        dout_pay,
   input logic               fwd_valid,
   input logic [63:0]        fwd_pay,
   input logic               rsp_valid,
   input logic               rsp_err,
   input logic [7:0]         rsp_op,
   input logic [31:0]        rsp_data,
   input logic [STAMP_W-1:0] rsp_stamp,
   input logic [31:0]        opt_out
);
   logic ctl, loc;
   assign ctl = in_valid && ctl_en && in_vpi == RSV_VPI && in_vci == RSV_VCI;
   assign loc = ctl && in_pay[55:48] == my_port;

   p_data_pass_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ctl) |=> (dout_valid && dout_vpi == $past(in_vpi) && dout_pay == $past(in_pay)));
   p_ctl_removed_r2: assert property (@(posedge clk) disable iff (rst)
      ctl |=> !dout_valid);
   p_fwd_r3: assert property (@(posedge clk) disable iff (rst)
      (ctl && !loc) |=> (fwd_valid && !rsp_valid && fwd_pay == $past(in_pay)));
   p_one_out_r3: assert property (@(posedge clk) disable iff (rst)
      $countones({dout_valid, fwd_valid, rsp_valid}) <= 1);
   p_rsp_r4: assert property (@(posedge clk) disable iff (rst)
      loc |=> (rsp_valid && rsp_op == $past(in_pay[63:56])));
   p_opt_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !(loc && in_pay[63:56] == 8'h03) |=> $stable(opt_out));
   p_stamp_step_r8: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && $past(rsp_valid)) |-> rsp_stamp == $past(rsp_stamp) + STAMP_W'(1));
   p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_err) |-> rsp_data == 32'h0);
endmodule

bind ccell_handler ccell_handler_chk #(
   .VPI_W(VPI_W), .VCI_W(VCI_W), .STAMP_W(STAMP_W), .RSV_VPI(RSV_VPI), .RSV_VCI(RSV_VCI)
) u_chk (
   .clk(clk), .rst(rst), .ctl_en(ctl_en), .my_port(my_port), .in_valid(in_valid),
   .in_vpi(in_vpi), .in_vci(in_vci), .in_pay(in_pay), .dout_valid(dout_valid),
   .dout_vpi(dout_vpi), .dout_pay(dout_pay), .fwd_valid(fwd_valid), .fwd_pay(fwd_pay),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_op(rsp_op), .rsp_data(rsp_data),
   .rsp_stamp(rsp_stamp), .opt_out(opt_out)
);

// File: tb/ccell_handler_tb.sv
module ccell_handler_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ctl_en = 1'b1;
   logic [7:0] my_port = 8'd5;
   logic in_valid = 1'b0;
   logic [7:0] in_vpi = '0;
   logic [15:0] in_vci = '0;
   logic [63:0] in_pay = '0;
   logic dout_valid, fwd_valid, rsp_valid, rsp_err;
   logic [7:0] dout_vpi, rsp_op;
   logic [15:0] dout_vci, rsp_addr;
   logic [63:0] dout_pay, fwd_pay;
   logic [31:0] rsp_data, rsp_stamp, opt_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ccell_handler #(.CNT_W(8)) u_dut (
      .clk(clk), .rst(rst), .ctl_en(ctl_en), .my_port(my_port), .in_valid(in_valid),
      .in_vpi(in_vpi), .in_vci(in_vci), .in_pay(in_pay), .dout_valid(dout_valid),
      .dout_vpi(dout_vpi), .dout_vci(dout_vci), .dout_pay(dout_pay), .fwd_valid(fwd_valid),
      .fwd_pay(fwd_pay), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_op(rsp_op),
      .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rsp_stamp(rsp_stamp), .opt_out(opt_out));

   // behavioural reference state
   logic [15:0] m_tab [16];
   logic [7:0]  m_vcc [16];
   logic [7:0]  m_link;
   logic [31:0] m_opt;
   int          m_tick;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] cmd(input logic [7:0] op, input logic [7:0] tgt,
                                       input logic [15:0] a, input logic [31:0] d);
      return {op, tgt, a, d};
   endfunction

   task automatic step(input bit v, input logic [7:0] vpi, input logic [15:0] vci,
                       input logic [63:0] pay, input string req);
      bit is_ctl, loc, fwd, dat, ok, e_err;
      logic [31:0] e_data;
      logic [15:0] e_vci;
      logic [7:0] op;
      logic [15:0] a;
      is_ctl = v && ctl_en && vpi == 8'h00 && vci == 16'h0003;
      loc = is_ctl && pay[55:48] == my_port;
      fwd = is_ctl && !loc;
      dat = v && !is_ctl;
      op = pay[63:56];
      a = pay[47:32];
      ok = a < 16;
      e_err = 0;
      e_data = 0;
      e_vci = m_tab[vci[3:0]];
      if (loc) begin
         case (op)
            8'h01: if (ok) e_data = {16'h0, m_tab[a[3:0]]}; else e_err = 1;
            8'h02: if (ok) begin e_data = pay[31:0]; m_tab[a[3:0]] = pay[15:0]; end else e_err = 1;
            8'h03: begin e_data = pay[31:0]; m_opt = pay[31:0]; end
            8'h06: e_data = m_opt;
            8'h04: e_data = {24'h0, m_link};
            8'h05: if (ok) e_data = {24'h0, m_vcc[a[3:0]]}; else e_err = 1;
            default: e_err = 1;
         endcase
      end
      if (dat) begin
         m_link = m_link + 1;
         m_vcc[vci[3:0]] = m_vcc[vci[3:0]] + 1;
      end
      in_valid = v; in_vpi = vpi; in_vci = vci; in_pay = pay;
      @(posedge clk);
      #2;
      chk(dout_valid == dat, req, "dout_valid", 64'(dout_valid), 64'(dat));
      chk(fwd_valid == fwd, req, "fwd_valid", 64'(fwd_valid), 64'(fwd));
      chk(rsp_valid == loc, req, "rsp_valid", 64'(rsp_valid), 64'(loc));
      chk(opt_out == m_opt, req, "opt_out", 64'(opt_out), 64'(m_opt));
      if (dat) begin
         chk(dout_vci == e_vci, req, "dout_vci", 64'(dout_vci), 64'(e_vci));
         chk(dout_vpi == vpi && dout_pay == pay, req, "dout_pay", dout_pay, pay);
      end
      if (fwd) chk(fwd_pay == pay, req, "fwd_pay", fwd_pay, pay);
      if (loc) begin
         chk(rsp_err == e_err, req, "rsp_err", 64'(rsp_err), 64'(e_err));
         chk(rsp_data == e_data, req, "rsp_data", 64'(rsp_data), 64'(e_data));
         chk(rsp_op == op && rsp_addr == a, req, "rsp_op_addr", {rsp_op, rsp_addr}, {op, a});
         chk(rsp_stamp == 32'(m_tick), req, "rsp_stamp", 64'(rsp_stamp), 64'(m_tick));
      end
      m_tick++;
   endtask

   task automatic ctl_cmd(input logic [7:0] op, input logic [15:0] a, input logic [31:0] d,
                          input string req);
      step(1, 8'h00, 16'h0003, cmd(op, 8'd5, a, d), req);
   endtask

   task automatic data(input logic [7:0] vpi, input logic [15:0] vci, input string req);
      step(1, vpi, vci, {vci, vpi, 8'hA5, vci, 16'h5A5A}, req);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin m_tab[i] = 0; m_vcc[i] = 0; end
      m_link = 0; m_opt = 0; m_tick = 0;
      repeat (3) @(posedge clk);
      #2;
      // R11: reset state
      chk(!dout_valid && !fwd_valid && !rsp_valid, "R11", "valids", 64'({dout_valid, fwd_valid, rsp_valid}), 64'h0);
      chk(opt_out == 0, "R11", "opt_out", 64'(opt_out), 64'h0);
      rst = 0;
      step(0, 0, 0, 0, "R11");
      ctl_cmd(8'h04, 16'h0, 32'h0, "R11");
      ctl_cmd(8'h01, 16'h7, 32'h0, "R11");
      // R1: data cells with zeroed table
      data(8'h11, 16'h0021, "R1");
      data(8'h22, 16'h0107, "R1");
      step(0, 0, 0, 0, "R1");
      // R4: table writes then use
      ctl_cmd(8'h02, 16'h1, 32'hDEAD_4321, "R4");
      ctl_cmd(8'h02, 16'h7, 32'h0000_0777, "R4");
      data(8'h33, 16'h0011, "R4");
      data(8'h44, 16'h0007, "R1");
      ctl_cmd(8'h01, 16'h1, 32'h0, "R4");
      ctl_cmd(8'h01, 16'hF, 32'h0, "R4");
      // R2: reserved cell with reception disabled is data
      ctl_en = 0;
      step(1, 8'h00, 16'h0003, cmd(8'h03, 8'd5, 16'h0, 32'hFFFF_FFFF), "R2");
      ctl_en = 1;
      data(8'h00, 16'h0004, "R2");
      // R3: foreign target is forwarded, not executed
      step(1, 8'h00, 16'h0003, cmd(8'h03, 8'd7, 16'h0, 32'h1234_5678), "R3");
      step(1, 8'h00, 16'h0003, cmd(8'h02, 8'd9, 16'h1, 32'h0), "R3");
      ctl_cmd(8'h01, 16'h1, 32'h0, "R3");
      // R5: option register
      ctl_cmd(8'h03, 16'h0, 32'hCAFE_F00D, "R5");
      ctl_cmd(8'h06, 16'h0, 32'h0, "R5");
      data(8'h01, 16'h0002, "R5");
      // R6 R7 R8: counters and stamps
      ctl_cmd(8'h04, 16'h0, 32'h0, "R6");
      ctl_cmd(8'h05, 16'h7, 32'h0, "R7");
      ctl_cmd(8'h05, 16'h3, 32'h0, "R7");
      step(0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, "R8");
      ctl_cmd(8'h04, 16'h0, 32'h0, "R8");
      // R9: errors change nothing
      ctl_cmd(8'h7F, 16'h0, 32'h1, "R9");
      ctl_cmd(8'h02, 16'h0020, 32'hBEEF, "R9");
      ctl_cmd(8'h05, 16'h0010, 32'h0, "R9");
      ctl_cmd(8'h00, 16'h1, 32'h0, "R9");
      ctl_cmd(8'h06, 16'h0, 32'h0, "R9");
      ctl_cmd(8'h01, 16'h0, 32'h0, "R9");
      // R10: wrap and no clear on read
      for (int i = 0; i < 260; i++) data(8'h09, 16'h0009, "R10");
      ctl_cmd(8'h05, 16'h9, 32'h0, "R10");
      ctl_cmd(8'h05, 16'h9, 32'h0, "R10");
      ctl_cmd(8'h04, 16'h0, 32'h0, "R10");
      data(8'h09, 16'h0019, "R10");
      ctl_cmd(8'h05, 16'h9, 32'h0, "R10");
      step(0, 0, 0, 0, "R1");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule